// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit carries out the four single-bit instructions of a 16/32-bit CISC core: test a bit, toggle it, clear it, or set it. The core supplies the instruction word, the operand (a 32-bit data register value or a memory byte placed in the low eight bits), the bit number, the current condition flags, and a flag that says whether the target is a data register. One cycle after a valid request the unit returns the modified operand and a write-enable. It also returns the flags with only Z updated and the number of clock cycles the instruction costs.

The instruction word is decoded without delay. That lets the core know before operand fetch whether the bit number comes from an extension word or from a data register, and which register that is. Effective-address work, bus cycles and extension-word fetch stay outside.

Top module: `bitop_unit`

## Requirements
- R1: Instruction bits 7:6 select the operation: 0 test, 1 toggle, 2 clear, 3 set.
- R2: When instruction bits 15:8 equal 8'h08, `imm_o` is 1 (bit number from an extension word). Otherwise `imm_o` is 0 and `src_reg_o` equals instruction bits 11:9, the data register holding the bit number.
- R3: The bit number on `bitsel_i` is reduced modulo 32 when `is_reg_i` is 1 and modulo 8 when it is 0.
- R4: In `flags_o`, bit 2 (Z) is 1 when the selected bit of the original operand is 0 and 0 when it is 1. Bits 4, 3, 1 and 0 equal those of `flags_i`.
- R5: A test returns the operand unchanged with `wr_en_o` at 0.
- R6: Toggle inverts, clear zeroes and set forces to 1 the selected bit only, with `wr_en_o` at 1.
- R7: For a memory target, result bits 31:8 equal the operand's bits 31:8.
- R8: In register-source form, `cycles_o` is 4 for test and 8 for the others. Test and clear add 2 when `is_reg_i` is 1.
- R9: In immediate form, `cycles_o` is 8 for test and 12 for the others, with the same +2 rule.
- R10: `valid_o` is 1 exactly one cycle after `valid_i` was 1. Without `valid_i`, the registered outputs hold their values.
- R11: During reset, `valid_o`, `wr_en_o`, `result_o`, `flags_o` and `cycles_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| opcode_i | input | 16 | Instruction word |
| operand_i | input | 32 | Target value; memory byte in bits 7:0 |
| bitsel_i | input | 32 | Bit number before folding |
| is_reg_i | input | 1 | 1: data register target, 0: memory byte |
| flags_i | input | 5 | Flags {X,N,Z,V,C} |
| imm_o | output | 1 | Immediate form decoded |
| src_reg_o | output | 3 | Register holding the bit number |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Modified operand |
| wr_en_o | output | 1 | Write the result back |
| flags_o | output | 5 | Flags with Z updated |
| cycles_o | output | 5 | Instruction cycle count |

## Verification
The bench aims at bit numbers beyond the operand width: 35 on a register and 8, 9 and 13 on a memory byte. A unit that skipped the folding, or folded with the wrong modulus, would touch the wrong bit or none. Vectors hit bit 31 and bit 7 with the bit already set and already clear. A design that took Z from the result instead of the original would invert Z for set and clear. All eight cycle-count cases appear, including the +2 on clear of a register, which a naive table tied only to test would miss. Idle cycles must leave the registered outputs frozen.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    BOP_TST = 2'd0,
    BOP_CHG = 2'd1,
    BOP_CLR = 2'd2,
    BOP_SET = 2'd3
  } bop_e;

  localparam logic [7:0] IMM_PREFIX = 8'h08;
  localparam int FLG_W = 5;
  localparam int FLG_Z = 2;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [15:0] opcode_i,
  output bop_e        op_o,
  output logic        imm_o,
  output logic [2:0]  src_reg_o
);
  assign op_o      = bop_e'(opcode_i[7:6]);
  assign imm_o     = (opcode_i[15:8] == IMM_PREFIX);
  assign src_reg_o = opcode_i[11:9];
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_W  = 8
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] bitsel_i,
  input  logic              is_reg_i,
  input  bop_e              op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              z_o,
  output logic              we_o
);
  localparam int REG_IDX_W = $clog2(DATA_W);
  localparam int MEM_IDX_W = $clog2(MEM_W);

  logic [REG_IDX_W-1:0] idx;
  logic [DATA_W-1:0]    mask;

  // fold bit number by target kind
  assign idx  = is_reg_i ? bitsel_i[REG_IDX_W-1:0]
                         : {{(REG_IDX_W-MEM_IDX_W){1'b0}}, bitsel_i[MEM_IDX_W-1:0]};
  assign mask = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
  assign z_o  = ~|(operand_i & mask);
  assign we_o = (op_i != BOP_TST);

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign result_o[g] = (op_i == BOP_CHG) ? (operand_i[g] ^  mask[g]) :
                         (op_i == BOP_CLR) ? (operand_i[g] & ~mask[g]) :
                         (op_i == BOP_SET) ? (operand_i[g] |  mask[g]) :
                                             operand_i[g];
  end

  always_comb begin
    assert_single_bit_R6: assert ($countones(result_o ^ operand_i) <= 1)
      else $error("more than one bit modified");
    assert_mem_upper_R7: assert (is_reg_i ||
        (result_o[DATA_W-1:MEM_W] == operand_i[DATA_W-1:MEM_W]))
      else $error("memory target upper bits changed");
  end
endmodule

// File: rtl/bitop_cycles.sv
module bitop_cycles
  import bitop_pkg::*;
#(
  parameter int CYC_W       = 5,
  parameter int REG_TST_CYC = 4,
  parameter int REG_MOD_CYC = 8,
  parameter int IMM_TST_CYC = 8,
  parameter int IMM_MOD_CYC = 12,
  parameter int REG_TGT_ADD = 2
) (
  input  bop_e             op_i,
  input  logic             imm_i,
  input  logic             is_reg_i,
  output logic [CYC_W-1:0] cycles_o
);
  logic [CYC_W-1:0] base;
  logic             extra;

  always_comb begin
    if (op_i == BOP_TST) base = imm_i ? CYC_W'(IMM_TST_CYC) : CYC_W'(REG_TST_CYC);
    else                 base = imm_i ? CYC_W'(IMM_MOD_CYC) : CYC_W'(REG_MOD_CYC);
  end

  // test and clear pay extra on a register target
  assign extra    = is_reg_i && ((op_i == BOP_TST) || (op_i == BOP_CLR));
  assign cycles_o = base + (extra ? CYC_W'(REG_TGT_ADD) : '0);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_W  = 8,
  parameter int CYC_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [15:0]       opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] bitsel_i,
  input  logic              is_reg_i,
  input  logic [FLG_W-1:0]  flags_i,
  output logic              imm_o,
  output logic [2:0]        src_reg_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic [CYC_W-1:0]  cycles_o
);
  bop_e              op;
  logic              imm;
  logic [DATA_W-1:0] res_d;
  logic              z_d;
  logic              we_d;
  logic [CYC_W-1:0]  cyc_d;
  logic [FLG_W-1:0]  flg_d;

  bitop_decode u_dec (
    .opcode_i  (opcode_i),
    .op_o      (op),
    .imm_o     (imm),
    .src_reg_o (src_reg_o)
  );

  bitop_alu #(.DATA_W(DATA_W), .MEM_W(MEM_W)) u_alu (
    .operand_i (operand_i),
    .bitsel_i  (bitsel_i),
    .is_reg_i  (is_reg_i),
    .op_i      (op),
    .result_o  (res_d),
    .z_o       (z_d),
    .we_o      (we_d)
  );

  bitop_cycles #(.CYC_W(CYC_W)) u_cyc (
    .op_i     (op),
    .imm_i    (imm),
    .is_reg_i (is_reg_i),
    .cycles_o (cyc_d)
  );

  assign imm_o = imm;

  always_comb begin
    flg_d        = flags_i;
    flg_d[FLG_Z] = z_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
      cycles_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        wr_en_o  <= we_d;
        flags_o  <= flg_d;
        cycles_o <= cyc_d;
      end
    end
  end

  assert_valid_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(cycles_o) && $stable(flags_o)));
  assert_test_nowrite_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[7:6] == 2'd0) |=> !wr_en_o);
  assert_flags_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (flags_o[4:3] == $past(flags_i[4:3]) && flags_o[1:0] == $past(flags_i[1:0])));
  assert_cyc_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!cycles_o[0] && cycles_o >= CYC_W'(4) && cycles_o <= CYC_W'(14)));
endmodule

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
  typedef struct packed {
    logic [15:0] opc;
    logic [31:0] opnd;
    logic [31:0] bsel;
    logic        rg;
    logic [4:0]  flg;
    logic [31:0] res;
    logic        we;
    logic [4:0]  eflg;
    logic [4:0]  cyc;
    logic        imm;
    logic [2:0]  src;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0100, 32'h0000_0010, 32'd4,         1'b1, 5'b10101, 32'h0000_0010, 1'b0, 5'b10001, 5'd6,  1'b0, 3'd0},
    '{16'h0340, 32'h8000_0000, 32'd35,        1'b1, 5'b00000, 32'h8000_0008, 1'b1, 5'b00100, 5'd8,  1'b0, 3'd1},
    '{16'h0580, 32'hFFFF_FFFF, 32'd31,        1'b1, 5'b11111, 32'h7FFF_FFFF, 1'b1, 5'b11011, 5'd10, 1'b0, 3'd2},
    '{16'h07D0, 32'hABCD_1200, 32'd13,        1'b0, 5'b01010, 32'hABCD_1220, 1'b1, 5'b01110, 5'd8,  1'b0, 3'd3},
    '{16'h0800, 32'h0000_0001, 32'd32,        1'b1, 5'b00100, 32'h0000_0001, 1'b0, 5'b00000, 5'd10, 1'b1, 3'd0},
    '{16'h0850, 32'h1234_5680, 32'd7,         1'b0, 5'b10000, 32'h1234_5600, 1'b1, 5'b10000, 5'd12, 1'b1, 3'd0},
    '{16'h0890, 32'h0000_00FF, 32'd9,         1'b0, 5'b00111, 32'h0000_00FD, 1'b1, 5'b00011, 5'd12, 1'b1, 3'd0},
    '{16'h0880, 32'h0000_0000, 32'd2,         1'b1, 5'b00000, 32'h0000_0000, 1'b1, 5'b00100, 5'd14, 1'b1, 3'd0},
    '{16'h08C0, 32'h0000_0000, 32'd31,        1'b1, 5'b11011, 32'h8000_0000, 1'b1, 5'b11111, 5'd12, 1'b1, 3'd0},
    '{16'h08D0, 32'h0000_0000, 32'd8,         1'b0, 5'b00000, 32'h0000_0001, 1'b1, 5'b00100, 5'd12, 1'b1, 3'd0},
    '{16'h0F00, 32'hFFFF_FF7F, 32'hFFFF_FFFF, 1'b0, 5'b00000, 32'hFFFF_FF7F, 1'b0, 5'b00100, 5'd4,  1'b0, 3'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [15:0] opcode = '0;
  logic [31:0] operand = '0;
  logic [31:0] bitsel = '0;
  logic        is_reg = 1'b0;
  logic [4:0]  flags_in = '0;
  logic        imm;
  logic [2:0]  src_reg;
  logic        valid_out;
  logic [31:0] result;
  logic        wr_en;
  logic [4:0]  flags_out;
  logic [4:0]  cycles;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitop_unit u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid_in),
    .opcode_i  (opcode),
    .operand_i (operand),
    .bitsel_i  (bitsel),
    .is_reg_i  (is_reg),
    .flags_i   (flags_in),
    .imm_o     (imm),
    .src_reg_o (src_reg),
    .valid_o   (valid_out),
    .result_o  (result),
    .wr_en_o   (wr_en),
    .flags_o   (flags_out),
    .cycles_o  (cycles)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 valid", 32'(valid_out), 32'd0);
    chk("R11 result", result, 32'd0);
    chk("R11 wr_en", 32'(wr_en), 32'd0);
    chk("R11 flags", 32'(flags_out), 32'd0);
    chk("R11 cycles", 32'(cycles), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      valid_in = 1'b1;
      opcode   = VECS[i].opc;
      operand  = VECS[i].opnd;
      bitsel   = VECS[i].bsel;
      is_reg   = VECS[i].rg;
      flags_in = VECS[i].flg;
      #1;
      chk("R2 imm", 32'(imm), 32'(VECS[i].imm));
      if (!VECS[i].imm) chk("R2 src_reg", 32'(src_reg), 32'(VECS[i].src));
      @(posedge clk);
      #1;
      chk("R10 valid", 32'(valid_out), 32'd1);
      chk("R1 R3 R5 R6 R7 result", result, VECS[i].res);
      chk("R5 R6 wr_en", 32'(wr_en), 32'(VECS[i].we));
      chk("R4 flags", 32'(flags_out), 32'(VECS[i].eflg));
      chk("R8 R9 cycles", 32'(cycles), 32'(VECS[i].cyc));
    end

    // idle cycle with changed inputs: outputs hold
    @(negedge clk);
    valid_in = 1'b0;
    opcode   = 16'h08C0;
    operand  = 32'h0;
    bitsel   = 32'd3;
    is_reg   = 1'b1;
    flags_in = 5'b11111;
    @(posedge clk);
    #1;
    chk("R10 idle valid", 32'(valid_out), 32'd0);
    chk("R10 idle result", result, 32'hFFFF_FF7F);
    chk("R10 idle cycles", 32'(cycles), 32'd4);
    chk("R10 idle flags", 32'(flags_out), 32'b00100);

    // toggle of an already set register bit 0 via bit number 64
    @(negedge clk);
    valid_in = 1'b1;
    opcode   = 16'h0E40;
    operand  = 32'h0000_0003;
    bitsel   = 32'd64;
    is_reg   = 1'b1;
    flags_in = 5'b00000;
    #1;
    chk("R2 src_reg", 32'(src_reg), 32'd7);
    @(posedge clk);
    #1;
    chk("R3 R6 toggle wrap", result, 32'h0000_0002);
    chk("R4 toggle z", 32'(flags_out), 32'd0);
    chk("R8 toggle cycles", 32'(cycles), 32'd8);
    @(negedge clk);
    valid_in = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule